// File: doc/BRIEF.md
# Stereo Stepped Volume with Soft Mute

This block scales a stereo stream of 24-bit signed audio samples by a separate 8-bit attenuation code per channel. The code is dB-linear: code 0x00 is the loudest setting at +24 dB, and each increment lowers the gain by 0.375 dB. Code 0x40 is unity gain and 0xFF is silence. Each channel has its own mute bit, and one shared mute bit silences both channels.

The code that is actually applied never jumps. It moves one code step toward the requested setting for each accepted sample pair, so volume changes and mutes fade in and out. A muted channel fades toward code 0xFF. The gain is not read from a 256-entry table. The top four code bits select an arithmetic right shift, where one shift equals 6 dB. The low four bits index a 16-entry fractional multiplier. Results saturate to the signed 24-bit range.

Top module: `stereo_soft_vol`

## Requirements
- R1: After reset, out_valid is 0, both outputs are 0, and both applied codes are 0x40. A sample sent with the volume inputs at 0x40 comes out unchanged.
- R2: An applied code k gives out = floor(in * 16 * F[k mod 16] / (32768 * 2^(k/16))), using integer division for k/16 and an arithmetic shift, so results round toward minus infinity. F[0] = 32768 and F[8] = 23170. Codes that are multiples of 16 therefore scale by exact powers of two: 0x00 is x16, 0x30 is x2, 0x40 is x1, 0x50 is x1/2.
- R3: An applied code of 0xFF yields exactly 0 on that channel.
- R4: Each sample pair is scaled by the applied code held before that sample. The applied code then moves one step toward its target. When no sample arrives, the applied code holds.
- R5: mute_left or mute_right sets that channel's target to 0xFF. Starting from 0x40, the muted channel reaches 0 on the 192nd sample. The other channel is unaffected.
- R6: mute_all sets the target of both channels to 0xFF.
- R7: A scaled value above 8388607 or below -8388608 is clamped to that limit.
- R8: out_valid is a one-cycle pulse two clock cycles after each in_valid cycle.
- R9: When a mute is released, the applied code climbs back one step per sample from 0xFF toward the volume input.
- R10: The two channels use their own codes independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample pair strobe |
| in_left | input | 24 | Left sample, signed |
| in_right | input | 24 | Right sample, signed |
| vol_left | input | 8 | Left volume code |
| vol_right | input | 8 | Right volume code |
| mute_left | input | 1 | Left soft mute |
| mute_right | input | 1 | Right soft mute |
| mute_all | input | 1 | Soft mute of both channels |
| out_valid | output | 1 | Output sample pair strobe |
| out_left | output | 24 | Scaled left sample |
| out_right | output | 24 | Scaled right sample |

## Verification
The bench first lets the applied codes settle fully. It then feeds pairs with opposite signs and different codes per channel. Codes that are whole multiples of 16 distinguish errors in the shift count, the fractional index or the base gain. Small negative inputs show whether results are floored or truncated toward zero. Large inputs at +24 dB expose wrapping in place of clamping. Sequences of samples held at one setting walk the ramp, and counting when the output reaches a known value pins down the step size and the code-before-step ordering. The mute, master-mute and release sequences show whether one channel leaks into the other.

// File: rtl/vol_pkg.sv
package vol_pkg;
    localparam int DATA_W   = 24;
    localparam int CODE_W   = 8;
    localparam int FRAC_W   = 16;
    localparam int IDX_W    = 4;
    localparam int SHIFT_W  = CODE_W - IDX_W;
    localparam int CHANS    = 2;
    localparam int BASE_LOG = 4;             // +24 dB base = 2^4
    localparam int FRAC_ONE = 15;            // F = 32768 means 1.0
    localparam int PROD_W   = DATA_W + FRAC_W + 1 + BASE_LOG;
    localparam logic [CODE_W-1:0] CODE_UNITY = 8'h40;
    localparam logic [CODE_W-1:0] CODE_MUTE  = {CODE_W{1'b1}};
    localparam logic signed [DATA_W-1:0] SAT_HI = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic signed [DATA_W-1:0] SAT_LO = {1'b1, {(DATA_W-1){1'b0}}};

    typedef logic signed [DATA_W-1:0] sample_t;
    typedef logic [CODE_W-1:0]        code_t;

    typedef struct packed {
        logic                 vld;
        logic                 silent;
        logic [SHIFT_W-1:0]   shift;
        logic [FRAC_W-1:0]    frac;
        sample_t              smp;
    } gain_stage_t;

    // 32768 * 2^(-i/16)
    function automatic logic [FRAC_W-1:0] frac_of(input logic [IDX_W-1:0] i);
        case (i)
            4'd0:  frac_of = 16'd32768;
            4'd1:  frac_of = 16'd31379;
            4'd2:  frac_of = 16'd30048;
            4'd3:  frac_of = 16'd28774;
            4'd4:  frac_of = 16'd27554;
            4'd5:  frac_of = 16'd26386;
            4'd6:  frac_of = 16'd25268;
            4'd7:  frac_of = 16'd24196;
            4'd8:  frac_of = 16'd23170;
            4'd9:  frac_of = 16'd22188;
            4'd10: frac_of = 16'd21247;
            4'd11: frac_of = 16'd20347;
            4'd12: frac_of = 16'd19484;
            4'd13: frac_of = 16'd18658;
            4'd14: frac_of = 16'd17867;
            default: frac_of = 16'd17109;
        endcase
    endfunction
endpackage

// File: rtl/vol_ramp.sv
module vol_ramp
    import vol_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  step,
    input  code_t vol,
    input  logic  mute,
    output code_t cur
);
    code_t tgt;
    assign tgt = mute ? CODE_MUTE : vol;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= CODE_UNITY;
        end else if (step) begin
            if (cur < tgt)      cur <= cur + 1'b1;
            else if (cur > tgt) cur <= cur - 1'b1;
        end
    end

    // R4
    step_size_chk: assert property (@(posedge clk) disable iff (rst)
        step |=> (cur == $past(cur) || cur == code_t'($past(cur) + 1'b1)
                  || cur == code_t'($past(cur) - 1'b1)));
    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step |=> cur == $past(cur));
    // R4
    at_target_chk: assert property (@(posedge clk) disable iff (rst)
        (step && cur == tgt) |=> cur == $past(cur));
endmodule

// File: rtl/vol_gain.sv
module vol_gain
    import vol_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    in_vld,
    input  sample_t in_smp,
    input  code_t   code,
    output logic    out_vld,
    output sample_t out_smp
);
    gain_stage_t s1;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] scaled;
    sample_t                  clamped;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.vld <= in_vld;
            if (in_vld) begin
                s1.silent <= (code == CODE_MUTE);
                s1.shift  <= code[CODE_W-1:IDX_W];
                s1.frac   <= frac_of(code[IDX_W-1:0]);
                s1.smp    <= in_smp;
            end
        end
    end

    always_comb begin
        prod   = PROD_W'(s1.smp) * $signed({1'b0, s1.frac});
        scaled = (prod <<< BASE_LOG) >>> (FRAC_ONE + int'(s1.shift));
        if (s1.silent)                      clamped = '0;
        else if (scaled > PROD_W'(SAT_HI))  clamped = SAT_HI;
        else if (scaled < PROD_W'(SAT_LO))  clamped = SAT_LO;
        else                                clamped = scaled[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            out_smp <= '0;
        end else begin
            out_vld <= s1.vld;
            if (s1.vld) out_smp <= clamped;
        end
    end

    // R3
    silent_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (s1.vld && s1.silent) |=> (out_vld && out_smp == '0));
endmodule

// File: rtl/stereo_soft_vol.sv
module stereo_soft_vol
    import vol_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_left,
    input  logic signed [DATA_W-1:0] in_right,
    input  logic [CODE_W-1:0]        vol_left,
    input  logic [CODE_W-1:0]        vol_right,
    input  logic                     mute_left,
    input  logic                     mute_right,
    input  logic                     mute_all,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_left,
    output logic signed [DATA_W-1:0] out_right
);
    sample_t din  [CHANS];
    sample_t dout [CHANS];
    code_t   vol  [CHANS];
    code_t   cur  [CHANS];
    logic    mute [CHANS];
    logic    vld  [CHANS];

    assign din[0]  = in_left;
    assign din[1]  = in_right;
    assign vol[0]  = vol_left;
    assign vol[1]  = vol_right;
    assign mute[0] = mute_left  | mute_all;
    assign mute[1] = mute_right | mute_all;

    for (genvar c = 0; c < CHANS; c++) begin : g_ch
        vol_ramp u_ramp (
            .clk  (clk),
            .rst  (rst),
            .step (in_valid),
            .vol  (vol[c]),
            .mute (mute[c]),
            .cur  (cur[c])
        );
        vol_gain u_gain (
            .clk     (clk),
            .rst     (rst),
            .in_vld  (in_valid),
            .in_smp  (din[c]),
            .code    (cur[c]),
            .out_vld (vld[c]),
            .out_smp (dout[c])
        );
    end

    assign out_valid = vld[0] & vld[1];
    assign out_left  = dout[0];
    assign out_right = dout[1];

    // R8
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##1 out_valid);
    // R8
    chan_sync_chk: assert property (@(posedge clk) disable iff (rst)
        vld[0] == vld[1]);
endmodule

// File: tb/stereo_soft_vol_test.sv
module stereo_soft_vol_test;
    logic clk = 0;
    logic rst = 1;
    logic in_valid = 0;
    logic signed [23:0] in_left = 0, in_right = 0;
    logic [7:0] vol_left = 8'h40, vol_right = 8'h40;
    logic mute_left = 0, mute_right = 0, mute_all = 0;
    logic out_valid;
    logic signed [23:0] out_left, out_right;

    int n_run = 0, n_fail = 0;
    int gl, gr;

    always #10 clk = ~clk;

    stereo_soft_vol uut (.*);

    localparam int NV = 8;
    localparam logic [7:0] TV_VL[NV] = '{8'h40, 8'h50, 8'h00, 8'h00, 8'h60, 8'h48, 8'hFF, 8'hF0};
    localparam logic [7:0] TV_VR[NV] = '{8'h40, 8'h30, 8'h10, 8'h00, 8'h70, 8'h40, 8'h40, 8'hFF};
    localparam int TV_IL[NV] = '{1000000, 1000000, 100000, 1000000, -3, 1000000, 5000000, 8388607};
    localparam int TV_IR[NV] = '{-1000000, -1000000, -300000, -1000000, 1000, 0, 5000000, 7000000};
    localparam int TV_EL[NV] = '{1000000, 500000, 1600000, 8388607, -1, 707092, 0, 4095};
    localparam int TV_ER[NV] = '{-1000000, -2000000, -2400000, -8388608, 125, 0, 5000000, 0};

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input int l, input int r);
        @(negedge clk);
        in_valid = 1; in_left = l[23:0]; in_right = r[23:0];
        @(negedge clk);
        in_valid = 0;
        @(negedge clk);
        gl = int'(out_left);
        gr = int'(out_right);
    endtask

    task automatic settle();
        for (int i = 0; i < 260; i++) send(0, 0);
    endtask

    task automatic do_reset();
        rst = 1; in_valid = 0;
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R1 reset state
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 out_left", int'(out_left), 0);
        check("R1 out_right", int'(out_right), 0);
        send(123456, -654321);
        check("R1 unity left", gl, 123456);
        check("R1 unity right", gr, -654321);

        // R8 latency: strobe two cycles after input, one cycle wide
        @(negedge clk);
        in_valid = 1; in_left = 0; in_right = 0;
        @(negedge clk);
        in_valid = 0;
        check("R8 not at one cycle", int'(out_valid), 0);
        @(negedge clk);
        check("R8 at two cycles", int'(out_valid), 1);
        @(negedge clk);
        check("R8 single pulse", int'(out_valid), 0);

        // Table: R2 R3 R7 R10
        for (int v = 0; v < NV; v++) begin
            vol_left = TV_VL[v]; vol_right = TV_VR[v];
            settle();
            send(TV_IL[v], TV_IR[v]);
            check($sformatf("R2/R3/R7/R10 vec%0d left", v), gl, TV_EL[v]);
            check($sformatf("R2/R3/R7/R10 vec%0d right", v), gr, TV_ER[v]);
        end

        // R4: idle holds code, ramp one step per sample
        do_reset();
        vol_left = 8'h50; vol_right = 8'h40;
        repeat (40) @(negedge clk);
        send(1000000, 1000000);
        check("R4 first sample at old code", gl, 1000000);
        for (int i = 0; i < 14; i++) send(1000000, 1000000);
        send(1000000, 1000000);
        n_run++;
        if (!(gl > 500000 && gl < 1000000)) begin
            n_fail++;
            $display("FAIL R4 sample16 actual=%0d expected=between 500000 and 1000000", gl);
        end
        send(1000000, 1000000);
        check("R4 sample17 reaches target", gl, 500000);
        send(1000000, 1000000);
        check("R4 stays at target", gl, 500000);

        // R5: per-channel mute ramps to zero on sample 192
        do_reset();
        vol_left = 8'h40; vol_right = 8'h40; mute_left = 1;
        for (int i = 0; i < 190; i++) send(4000000, 4000000);
        send(4000000, 4000000);
        n_run++;
        if (gl == 0) begin
            n_fail++;
            $display("FAIL R5 sample191 actual=%0d expected=nonzero", gl);
        end
        send(4000000, 4000000);
        check("R5 muted left zero", gl, 0);
        check("R5 right unaffected", gr, 4000000);

        // R6: master mute
        mute_left = 0; mute_all = 1;
        for (int i = 0; i < 192; i++) send(4000000, 4000000);
        check("R6 left zero", gl, 0);
        check("R6 right zero", gr, 0);

        // R9: release ramps back up
        mute_all = 0;
        send(4000000, 4000000);
        check("R9 first after release still silent", gl, 0);
        send(4000000, 4000000);
        n_run++;
        if (gl == 0 || gl >= 4000000) begin
            n_fail++;
            $display("FAIL R9 second after release actual=%0d expected=small nonzero", gl);
        end
        for (int i = 0; i < 200; i++) send(4000000, 4000000);
        check("R9 left restored", gl, 4000000);
        check("R9 right restored", gr, 4000000);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule